// File: doc/BRIEF.md
# Serial-Bus 256-Byte EEPROM Slave Controller

This block is the digital front end of a small non-volatile memory that sits on a two-wire I2C bus as a slave. It watches the serial clock and data lines and recognises start and stop conditions. It accepts a selection byte carrying a fixed device code and a three-bit chip address. It keeps an 8-bit word pointer into a 256 x 8 array. Writes go into an eight-entry page latch first. A stop condition then commits the latched bytes to the array during a self-timed programming cycle.

The programming cycle is timed from the block clock. A divide-by-128 prescaler drives a 16-step timer, so the cycle lasts 2048 clock cycles. While it runs, the device does not acknowledge its selection byte, so a master polls until it gets an acknowledge. Reads return array data most significant bit first. The pointer advances after each byte sent, so a master can set the address with a write that carries no data, issue a repeated start, and then read any number of bytes in sequence. Up to eight devices can share a bus, each told apart by its three address straps.

The array is a synchronous register file with no reset. The SDA line is open-drain: the block only ever pulls it low, through an output enable.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the block does not pull SDA (sda_oe_o = 0), no programming cycle is running, and SDA is never pulled while the controller is idle.
- R2: A selection byte is acknowledged only when its bits 7..4 equal 4'b1010 and its bits 3..1 equal strap_i. On a mismatch the block gives no acknowledge and ignores every later byte until the next start condition.
- R3: Bits travel most significant bit first in both directions. Bit 0 of the selection byte chooses the direction (1 = read, 0 = write).
- R4: The block acknowledges the selection byte, the word address byte and every write data byte by pulling SDA low during the ninth clock. It asserts the pull only while SCL is low.
- R5: A single data byte written to an address and followed by a stop is returned by a later read of that address.
- R6: In a page write, address bits 2..0 increment and wrap inside the 8-byte page while bits 7..3 stay fixed. A ninth or later byte overwrites the latch entry it wraps onto.
- R7: A programming cycle starts only on a stop that follows at least one acknowledged data byte. A stop after only an address byte leaves the device immediately selectable. The array is written only inside a programming cycle.
- R8: A programming cycle lasts exactly 128 x 16 = 2048 clock cycles. During it the selection byte is not acknowledged, and after it ends the selection byte is acknowledged again.
- R9: A random read (selection byte for write, address byte, repeated start, selection byte for read) returns the byte stored at that address.
- R10: In a sequential read the address advances by one for each byte, wrapping from 255 to 0. A master not-acknowledge followed by a stop ends the read with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Chip-address straps matched against selection byte bits 3..1 |
| sda_oe_o | output | 1 | When 1 the block pulls SDA low; when 0 it releases SDA |

## Verification
A corrupted word pointer or page-latch entry stays hidden until a read returns a wrong byte. So every write in the bench is followed by a read-back, and the page test reads the whole page plus the neighbouring byte, which exposes wrap and overwrite faults. A fault in the programming timer shows on the acknowledge bit of a selection byte. One probe placed well inside the 2048-cycle window and one placed after it catch a cycle that is missing, too short or never ends, within one byte time. A broken decode of the device code, the straps or the bus-condition detector shows as a wrong acknowledge on the very first byte of a transaction.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } bus_state_t;

endpackage

// File: rtl/i2c_line_cond.sv
// Synchronises SCL/SDA and derives clock edges and bus conditions.
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p_q, sda_p_q;
  logic scl_s, sda_s;

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= '1;
      sda_q   <= '1;
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_q   <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q   <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/page_buffer.sv
// Page latch: gathers bytes, then writes valid entries one per clock on commit.
module page_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              commit,
  output logic              pending,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [BASE_W-1:0]     base_q, base_d;
  logic                  run_q, run_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  clr_all;

  assign clr_all = (clear && !run_q) || (run_q && idx_q == LAST_IDX);

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_entry
    logic hit;
    assign hit = load_en && (load_addr[IDX_W-1:0] == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (hit) data_q[k] <= load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q[k] <= 1'b0;
      else if (clr_all) valid_q[k] <= 1'b0;
      else if (hit)     valid_q[k] <= 1'b1;
    end
  end

  always_comb begin
    base_d = base_q;
    run_d  = run_q;
    idx_d  = idx_q;
    if (load_en) base_d = load_addr[ADDR_W-1:IDX_W];
    if (run_q) begin
      idx_d = idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) run_d = 1'b0;
    end else if (commit) begin
      run_d = 1'b1;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      run_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      base_q <= base_d;
      run_q  <= run_d;
      idx_q  <= idx_d;
    end
  end

  assign pending   = |valid_q;
  assign mem_we    = run_q && valid_q[idx_q];
  assign mem_waddr = {base_q, idx_q};
  assign mem_wdata = data_q[idx_q];

endmodule

// File: rtl/write_cycle_timer.sv
// Self-timed programming window: prescaler followed by step timer.
module write_cycle_timer #(
  parameter int PRESCALE = 128,
  parameter int STEPS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int PW = $clog2(PRESCALE);
  localparam int SW = $clog2(STEPS);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] step_q, step_d;
  logic          busy_q, busy_d;

  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (pre_q == PW'(PRESCALE - 1)) begin
        pre_d = '0;
        if (step_q == SW'(STEPS - 1)) busy_d = 1'b0;
        else                          step_d = step_q + SW'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      pre_d  = '0;
      step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/eeprom_array.sv
// Storage array model: one write port, registered read port.
module eeprom_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
    rdata_q <= cell_q[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int PAGE_BYTES  = 8,
  parameter int PRESCALE    = 128,
  parameter int TIMER_STEPS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst_n    (rst_ni),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  bus_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sreg_q, sreg_d;
  logic              pull_q, pull_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  logic              lat_load, lat_clear, commit, lat_pending, busy;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BYTE_W-1:0] mem_wdata, rd_byte;
  logic              byte_full, sel_match;

  page_buffer #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clear    (lat_clear),
    .load_en  (lat_load),
    .load_addr(ptr_q),
    .load_data(sreg_q),
    .commit   (commit),
    .pending  (lat_pending),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  write_cycle_timer #(.PRESCALE(PRESCALE), .STEPS(TIMER_STEPS)) u_timer (
    .clk  (clk),
    .rst_n(rst_ni),
    .start(commit),
    .busy (busy)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(ptr_q),
    .rdata(rd_byte)
  );

  assign byte_full = (cnt_q == FULL);
  assign sel_match = (sreg_q[7:4] == DEV_CODE) && (sreg_q[3:1] == strap_i) && !busy;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sreg_d    = sreg_q;
    pull_d    = pull_q;
    rw_d      = rw_q;
    mack_d    = mack_q;
    ptr_d     = ptr_q;
    lat_load  = 1'b0;
    lat_clear = 1'b0;
    commit    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
      commit  = lat_pending;
    end else if (start_det) begin
      state_d   = ST_SEL;
      cnt_d     = '0;
      pull_d    = 1'b0;
      lat_clear = 1'b1;
    end else begin
      case (state_q)
        ST_SEL, ST_WADR, ST_WDAT: begin
          if (scl_rise && !byte_full) begin
            sreg_d = {sreg_q[BYTE_W-2:0], sda_lvl};
            cnt_d  = cnt_q + CNT_W'(1);
          end else if (scl_fall && byte_full) begin
            pull_d = 1'b1;
            if (state_q == ST_SEL) begin
              if (sel_match) begin
                rw_d    = sreg_q[0];
                state_d = ST_SEL_ACK;
              end else begin
                pull_d  = 1'b0;
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_WADR) begin
              ptr_d   = sreg_q;
              state_d = ST_WADR_ACK;
            end else begin
              lat_load = 1'b1;
              ptr_d    = {ptr_q[ADDR_W-1:IDX_W], ptr_q[IDX_W-1:0] + IDX_W'(1)};
              state_d  = ST_WDAT_ACK;
            end
          end
        end
        ST_SEL_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RDAT;
              sreg_d  = rd_byte;
              pull_d  = ~rd_byte[BYTE_W-1];
            end else begin
              state_d = ST_WADR;
              pull_d  = 1'b0;
            end
          end
        end
        ST_WADR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            pull_d  = 1'b0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise && !byte_full) begin
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q != '0) begin
            if (byte_full) begin
              pull_d  = 1'b0;
              ptr_d   = ptr_q + ADDR_W'(1);
              state_d = ST_RACK;
            end else begin
              sreg_d = {sreg_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sreg_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDAT;
              cnt_d   = '0;
              sreg_d  = rd_byte;
              pull_d  = ~rd_byte[BYTE_W-1];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sreg_q  <= sreg_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      ptr_q   <= ptr_d;
    end
  end

  assign sda_oe_o = pull_q;

endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 3,
  parameter int CYCLE_LEN = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input bus_state_t        state,
  input logic              sda_oe,
  input logic              scl,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic              mem_we,
  input logic              stop_det
);

  int unsigned busy_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= 0;
    else if (busy) busy_run_q <= busy_run_q + 1;
    else           busy_run_q <= 0;
  end

  logic in_wr, in_wr_q;
  assign in_wr = (state == ST_WDAT) || (state == ST_WDAT_ACK);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_wr_q <= 1'b0;
    else        in_wr_q <= in_wr;
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  p_pull_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  p_page_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && in_wr_q) |-> (ptr[ADDR_W-1:IDX_W] == $past(ptr[ADDR_W-1:IDX_W])));

  p_we_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEL_ACK) |-> !busy);

  p_cycle_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == CYCLE_LEN));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

endmodule

bind eeprom_i2c_slave eeprom_i2c_checker #(
  .ADDR_W   (ADDR_W),
  .IDX_W    (IDX_W),
  .CYCLE_LEN(PRESCALE * TIMER_STEPS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (state_q),
  .sda_oe  (pull_q),
  .scl     (scl_i),
  .busy    (busy),
  .ptr     (ptr_q),
  .mem_we  (mem_we),
  .stop_det(stop_det)
);

// File: tb/tb_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module tb_eeprom_i2c_slave;

  localparam int Q       = 100;   // quarter bit time in ns
  localparam int PROG_NS = 2200 * 10;
  localparam int NVEC    = 5;
  // {strap, address, data}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd0, 8'h00, 8'h5A},
    {3'd3, 8'h37, 8'hC3},
    {3'd5, 8'hFF, 8'h81},
    {3'd7, 8'h80, 8'h01},
    {3'd2, 8'h12, 8'hFE}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       m_scl, m_sda;
  logic [2:0] strap;
  logic       sda_oe;
  logic       sda_line;
  assign sda_line = m_sda & ~sda_oe;

  eeprom_i2c_slave dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_line),
    .strap_i (strap),
    .sda_oe_o(sda_oe)
  );

  int   errs = 0;
  int   checks = 0;
  bit   done = 1'b0;
  logic [7:0] mdl  [256];
  logic [7:0] rbuf [16];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(input logic [2:0] st, input logic rw);
    return {4'b1010, st, rw};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q;
    ack = (sda_line == 1'b0);
    #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; m_scl = 1'b1; #Q; b[i] = sda_line; #Q; m_scl = 1'b0;
    end
    #Q; m_sda = ~give_ack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] first);
    logic ack;
    bus_start();
    send_byte(sel(strap, 1'b0), ack); chk("R4 select ack (write)", ack, 1);
    send_byte(a, ack);                chk("R4 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(first + 8'(k), ack);  chk("R4 data ack", ack, 1);
      mdl[{a[7:3], a[2:0] + 3'(k)}] = first + 8'(k);
    end
    bus_stop();
  endtask

  task automatic read_rand(input logic [7:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(sel(strap, 1'b0), ack); chk("R9 dummy write select ack", ack, 1);
    send_byte(a, ack);                chk("R9 dummy write address ack", ack, 1);
    bus_start();
    send_byte(sel(strap, 1'b1), ack); chk("R9 read select ack", ack, 1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  initial begin
    logic ack;
    m_scl = 1'b1; m_sda = 1'b1; strap = 3'd0; rst_n = 1'b0;
    #100; rst_n = 1'b1; #100;
    chk("R1 SDA released after reset", sda_oe, 0);

    // table walk: single write then random read of the same address
    for (int i = 0; i < NVEC; i++) begin
      strap = VEC[i][18:16];
      write_seq(VEC[i][15:8], 1, VEC[i][7:0]);
      #PROG_NS;
      read_rand(VEC[i][15:8], 1);
      chk("R5 R3 single write read back", rbuf[0], mdl[VEC[i][15:8]]);
    end
    strap = 3'd2;

    // wrong device code, then a trailing byte that must be ignored
    bus_start();
    send_byte({4'b1011, strap, 1'b0}, ack); chk("R2 wrong code not acked", ack, 0);
    send_byte(8'h10, ack);                  chk("R2 later byte ignored", ack, 0);
    bus_stop();
    // wrong strap
    bus_start();
    send_byte(sel(3'd5, 1'b0), ack);        chk("R2 wrong strap not acked", ack, 0);
    bus_stop();
    chk("R1 SDA released when idle", sda_oe, 0);

    // address-only write then stop: no programming cycle
    bus_start();
    send_byte(sel(strap, 1'b0), ack);
    send_byte(8'h20, ack);
    bus_stop();
    bus_start();
    send_byte(sel(strap, 1'b0), ack);       chk("R7 no cycle after address-only stop", ack, 1);
    bus_stop();

    // page write with wrap and overwrite
    write_seq(8'h48, 1, 8'h77);
    #PROG_NS;
    write_seq(8'h43, 10, 8'hA0);
    #PROG_NS;
    read_rand(8'h40, 9);
    for (int k = 0; k < 9; k++)
      chk("R6 page wrap/overwrite read back", rbuf[k], mdl[8'h40 + k]);
    chk("R6 entry 0x43 overwritten", mdl[8'h43], 8'hA8);

    // busy window
    write_seq(8'h90, 1, 8'h5C);
    #(1000 * 10);
    bus_start();
    send_byte(sel(strap, 1'b0), ack);       chk("R8 select not acked while programming", ack, 0);
    bus_stop();
    #(1300 * 10);
    bus_start();
    send_byte(sel(strap, 1'b0), ack);       chk("R8 select acked after cycle", ack, 1);
    bus_stop();
    read_rand(8'h90, 1);
    chk("R5 byte written during probe test", rbuf[0], 8'h5C);

    // sequential read wrapping 255 -> 0
    write_seq(8'hFE, 1, 8'h3C);
    #PROG_NS;
    read_rand(8'hFE, 3);
    chk("R10 seq byte at 0xFE", rbuf[0], mdl[8'hFE]);
    chk("R10 seq byte at 0xFF", rbuf[1], mdl[8'hFF]);
    chk("R10 seq wrap to 0x00", rbuf[2], mdl[8'h00]);
    chk("R10 SDA released after NACK and stop", sda_oe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog (all requirements): actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule